// File: doc/BRIEF.md
# BCD Calendar Counter With 12/24-Hour Hours

The block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year, with a century marker held in the top bit of the month byte. A one-cycle `tick_1hz` pulse advances the seconds. Each field that wraps carries into the next one, so a single tick can ripple from the seconds all the way up to the century. The hour byte is stored in one of two layouts. In 24-hour layout it counts 00 to 23. In 12-hour layout it counts 1 to 12 with a PM flag. A control bit chooses the layout.

Software reaches every field through a small register port. It can write one byte per cycle, and the read data is a combinational function of the address. Two status flags sit in a second control byte. The first reports that the oscillator stopped; reset sets it and only an explicit clear removes it. The second latches a voltage-low indication from an input pin. Day-of-month limits follow the month length, and February takes a 29th day whenever the two-digit year is a multiple of four.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hours 0x12 (12 AM in 12-hour layout), weekday 0x00, day 0x01, month 0x01 (century 0), year 0x00, control-1 0x00, control-2 0x10 (with `volt_low_in` low). Addresses: seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5, year 6, control-1 14, control-2 15. Every other address reads 0x00.
- R2: Seconds and minutes occupy bits 6:0 and count BCD 00..59. At 59 a tick wraps the field to 00 and carries into the next field. Bit 7 of both bytes always reads 0, whatever value is written to it.
- R3: With control-1 bit 5 set (24-hour layout), the hour counts BCD 00..23. The hour advances when seconds and minutes are both 59 at a tick. On 23 it wraps to 00 and advances the date.
- R4: With control-1 bit 5 clear (12-hour layout), hour bits 4:0 hold BCD 1..12 and bit 5 is PM. From 11 the hour goes to 12 and PM toggles. From 12 it goes to 01 and PM is kept. The date advances only on 11 PM to 12 AM.
- R5: The weekday (bits 2:0) counts 0..6. It steps once per date advance and wraps from 6 to 0.
- R6: The day (bits 5:0) wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11, and 31 for the other months except February. The wrap steps the month (bits 4:0). Month 12 wraps to 01 and steps the year.
- R7: In February the last day is 29 when the BCD year is a multiple of four (including 00) and 28 otherwise.
- R8: The year byte counts BCD 00..99. Going from 99 to 00 toggles month bit 7 (the century). Writing the month byte loads the century from bit 7 of the written data.
- R9: Control-2 bit 4 (oscillator stopped, also output `osc_stopped`) is set by reset. Writing control-2 with bit 4 at 0 clears it. Writing 1 to bit 4 never sets it.
- R10: Control-2 bit 6 is set on the cycle after `volt_low_in` is high and then holds. A control-2 write with bit 6 at 0 clears it, but only while `volt_low_in` is low.
- R11: If a write and a tick happen in the same cycle, the written field takes the written value. The other fields still advance, and carries are computed from the values held before the write.
- R12: With neither a tick nor a write, no time or date field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| volt_low_in | input | 1 | Supply-low indication, latched into control-2 bit 6 |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| osc_stopped | output | 1 | Oscillator-stopped flag |

## Verification
A register write and a 1 Hz tick can fall in the same clock cycle. The bench provokes this by raising both strobes together, once while the seconds sit at 59 with the seconds field as the write target, and once with the minutes field as the target. It then reads the bytes back. In each case the written field must hold the written value, and the neighbouring field must show the advance or carry implied by the values held before the write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int WDAY_MAX = 6;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC  = 4'd0,
        RA_MIN  = 4'd1,
        RA_HOUR = 4'd2,
        RA_WDAY = 4'd3,
        RA_DAY  = 4'd4,
        RA_MON  = 4'd5,
        RA_YEAR = 4'd6,
        RA_CTL1 = 4'd14,
        RA_CTL2 = 4'd15
    } reg_addr_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
    } tod_t;

    typedef struct packed {
        logic [2:0] wday;
        logic [5:0] day;
        logic [4:0] mon;
        logic       cent;
        logic [7:0] year;
    } cal_t;

    // Two-digit BCD increment (no wrap handling; callers decide the limit).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of four when: tens even and units in {0,4,8},
    // or tens odd and units in {2,6}.
    function automatic logic leap_bcd(input logic [7:0] y);
        if (!y[4]) leap_bcd = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else       leap_bcd = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [5:0] month_len(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      month_len = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: month_len = 6'h30;
            default:                    month_len = 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tod_unit.sv
module rtc_tod_unit
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       mode24,
    input  logic       we_sec,
    input  logic       we_min,
    input  logic       we_hr,
    input  logic [6:0] wdata,
    output tod_t       tod,
    output logic       day_step
);

    tod_t nxt;
    logic sec_wrap;
    logic min_wrap;

    always_comb begin
        sec_wrap = (tod.sec == 7'h59);
        min_wrap = sec_wrap && (tod.min == 7'h59);
        nxt      = tod;
        day_step = 1'b0;
        if (tick) begin
            nxt.sec = sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, tod.sec}));
            if (sec_wrap)
                nxt.min = (tod.min == 7'h59) ? 7'h00 : 7'(bcd_inc({1'b0, tod.min}));
            if (min_wrap) begin
                if (mode24) begin
                    if (tod.hr == 6'h23) begin
                        nxt.hr   = 6'h00;
                        day_step = 1'b1;
                    end else begin
                        nxt.hr = 6'(bcd_inc({2'b00, tod.hr}));
                    end
                end else begin
                    // bit 5 = PM, bits 4:0 = BCD 1..12
                    if (tod.hr[4:0] == 5'h12) begin
                        nxt.hr = {tod.hr[5], 5'h01};
                    end else if (tod.hr[4:0] == 5'h11) begin
                        nxt.hr   = {~tod.hr[5], 5'h12};
                        day_step = tod.hr[5];
                    end else begin
                        nxt.hr = {tod.hr[5], 5'(bcd_inc({3'b000, tod.hr[4:0]}))};
                    end
                end
            end
        end
        // Writes override only their own field; carries above used old values.
        if (we_sec) nxt.sec = wdata[6:0];
        if (we_min) nxt.min = wdata[6:0];
        if (we_hr)  nxt.hr  = wdata[5:0];
    end

    always_ff @(posedge clk) begin
        if (rst) tod <= '{sec: 7'h00, min: 7'h00, hr: 6'h12};
        else     tod <= nxt;
    end

endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              day_step,
    input  logic              we_wday,
    input  logic              we_day,
    input  logic              we_mon,
    input  logic              we_year,
    input  logic [DATA_W-1:0] wdata,
    output cal_t              cal
);

    cal_t nxt;
    logic day_last;
    logic mon_last;

    always_comb begin
        day_last = (cal.day == month_len(cal.mon, leap_bcd(cal.year)));
        mon_last = day_last && (cal.mon == 5'h12);
        nxt      = cal;
        if (day_step) begin
            nxt.wday = (cal.wday >= 3'(WDAY_MAX)) ? 3'd0 : cal.wday + 3'd1;
            nxt.day  = day_last ? 6'h01 : 6'(bcd_inc({2'b00, cal.day}));
            if (day_last)
                nxt.mon = (cal.mon == 5'h12) ? 5'h01 : 5'(bcd_inc({3'b000, cal.mon}));
            if (mon_last) begin
                if (cal.year == 8'h99) begin
                    nxt.year = 8'h00;
                    nxt.cent = ~cal.cent;
                end else begin
                    nxt.year = bcd_inc(cal.year);
                end
            end
        end
        if (we_wday) nxt.wday = wdata[2:0];
        if (we_day)  nxt.day  = wdata[5:0];
        if (we_mon) begin
            nxt.mon  = wdata[4:0];
            nxt.cent = wdata[7];
        end
        if (we_year) nxt.year = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cal <= '{wday: 3'd0, day: 6'h01, mon: 5'h01, cent: 1'b0, year: 8'h00};
        else     cal <= nxt;
    end

endmodule

// File: rtl/rtc_ctrl_unit.sv
module rtc_ctrl_unit (
    input  logic clk,
    input  logic rst,
    input  logic vlow_in,
    input  logic we_ctl1,
    input  logic we_ctl2,
    input  logic wd_mode24,
    input  logic wd_osc,
    input  logic wd_vlow,
    output logic mode24,
    output logic osc_flag,
    output logic vlow_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode24    <= 1'b0;
            osc_flag  <= 1'b1;
            vlow_flag <= 1'b0;
        end else begin
            if (we_ctl1) mode24 <= wd_mode24;
            // only a zero written clears; a one never sets
            if (we_ctl2 && !wd_osc) osc_flag <= 1'b0;
            // a live low-voltage indication wins over a clearing write
            if (vlow_in)                  vlow_flag <= 1'b1;
            else if (we_ctl2 && !wd_vlow) vlow_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              volt_low_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              osc_stopped
);

    tod_t tod;
    cal_t cal;
    logic day_step;
    logic mode24;
    logic osc_flag;
    logic vlow_flag;

    logic we_sec, we_min, we_hr, we_wday, we_day, we_mon, we_year, we_ctl1, we_ctl2;

    assign we_sec  = reg_we && (reg_addr == RA_SEC);
    assign we_min  = reg_we && (reg_addr == RA_MIN);
    assign we_hr   = reg_we && (reg_addr == RA_HOUR);
    assign we_wday = reg_we && (reg_addr == RA_WDAY);
    assign we_day  = reg_we && (reg_addr == RA_DAY);
    assign we_mon  = reg_we && (reg_addr == RA_MON);
    assign we_year = reg_we && (reg_addr == RA_YEAR);
    assign we_ctl1 = reg_we && (reg_addr == RA_CTL1);
    assign we_ctl2 = reg_we && (reg_addr == RA_CTL2);

    rtc_tod_unit u_tod (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .mode24   (mode24),
        .we_sec   (we_sec),
        .we_min   (we_min),
        .we_hr    (we_hr),
        .wdata    (reg_wdata[6:0]),
        .tod      (tod),
        .day_step (day_step)
    );

    rtc_date_unit u_date (
        .clk      (clk),
        .rst      (rst),
        .day_step (day_step),
        .we_wday  (we_wday),
        .we_day   (we_day),
        .we_mon   (we_mon),
        .we_year  (we_year),
        .wdata    (reg_wdata),
        .cal      (cal)
    );

    rtc_ctrl_unit u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .vlow_in   (volt_low_in),
        .we_ctl1   (we_ctl1),
        .we_ctl2   (we_ctl2),
        .wd_mode24 (reg_wdata[5]),
        .wd_osc    (reg_wdata[4]),
        .wd_vlow   (reg_wdata[6]),
        .mode24    (mode24),
        .osc_flag  (osc_flag),
        .vlow_flag (vlow_flag)
    );

    always_comb begin
        case (reg_addr)
            RA_SEC:  reg_rdata = {1'b0, tod.sec};
            RA_MIN:  reg_rdata = {1'b0, tod.min};
            RA_HOUR: reg_rdata = {2'b00, tod.hr};
            RA_WDAY: reg_rdata = {5'b00000, cal.wday};
            RA_DAY:  reg_rdata = {2'b00, cal.day};
            RA_MON:  reg_rdata = {cal.cent, 2'b00, cal.mon};
            RA_YEAR: reg_rdata = cal.year;
            RA_CTL1: reg_rdata = {2'b00, mode24, 5'b00000};
            RA_CTL2: reg_rdata = {1'b0, vlow_flag, 1'b0, osc_flag, 4'b0000};
            default: reg_rdata = '0;
        endcase
    end

    assign osc_stopped = osc_flag;

endmodule

// File: rtl/rtc_calendar_core_checker.sv
module rtc_calendar_core_checker
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              volt_low_in,
    input tod_t              tod,
    input cal_t              cal,
    input logic              mode24,
    input logic              osc_q,
    input logic              vlow_q
);

    // R12: no tick, no write -> every field holds
    p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !reg_we) |=> ($stable(tod) && $stable(cal)));

    // R2: seconds at 59 wrap to 00 and the minute moves
    p_sec_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !reg_we && tod.sec == 7'h59) |=> (tod.sec == 7'h00 && tod.min != $past(tod.min)));

    // R3: 23:59:59 in 24-hour layout wraps the hour to 00
    p_hour24_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !reg_we && mode24 && tod.hr == 6'h23 && tod.min == 7'h59 && tod.sec == 7'h59)
        |=> (tod.hr == 6'h00));

    // R8: century moves only on a month write or a year at 99
    p_cent_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!(reg_we && reg_addr == RA_MON) && cal.year != 8'h99) |=> $stable(cal.cent));

    // R9: once clear, the oscillator flag never sets again
    p_osc_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !osc_q |=> !osc_q);

    // R10: a low-voltage indication is latched on the next cycle
    p_vlow_latch_r10: assert property (@(posedge clk) disable iff (rst)
        volt_low_in |=> vlow_q);

endmodule

bind rtc_calendar_core rtc_calendar_core_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_1hz    (tick_1hz),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .volt_low_in (volt_low_in),
    .tod         (tod),
    .cal         (cal),
    .mode24      (mode24),
    .osc_q       (osc_flag),
    .vlow_q      (vlow_flag)
);

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
    import rtc_cal_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       volt_low_in = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       osc_stopped;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [3:0] a;
        logic [7:0] v;
        string      tag;
    } item_t;
    item_t exp_q[$];

    event mon_go;
    event mon_done;

    always #5 clk = ~clk;

    rtc_calendar_core uut (
        .clk         (clk),
        .rst         (rst),
        .tick_1hz    (tick_1hz),
        .volt_low_in (volt_low_in),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .osc_stopped (osc_stopped)
    );

    // monitor: pops the expected item and compares with the read port
    initial begin
        forever begin
            @(mon_go);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                total++;
                if (reg_rdata !== it.v) begin
                    fails++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, it.a, reg_rdata, it.v);
                end
            end
            -> mon_done;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic wr_tick(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; tick_1hz = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [7:0] v, input string tag);
        item_t it;
        it.a = a; it.v = v; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        reg_addr = a;
        -> mon_go;
        @(mon_done);
    endtask

    task automatic set_eod();
        wr(RA_HOUR, 8'h23);
        wr(RA_MIN, 8'h59);
        wr(RA_SEC, 8'h59);
    endtask

    task automatic feb_case(input logic [7:0] y, input logic [7:0] exp_day, input logic [7:0] exp_mon);
        wr(RA_YEAR, y);
        wr(RA_MON, 8'h02);
        wr(RA_DAY, 8'h28);
        set_eod();
        tick1();
        chk(RA_DAY, exp_day, "R7 feb day");
        chk(RA_MON, exp_mon, "R7 feb month");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(RA_SEC,  8'h00, "R1 sec");
        chk(RA_MIN,  8'h00, "R1 min");
        chk(RA_HOUR, 8'h12, "R1 hour");
        chk(RA_WDAY, 8'h00, "R1 wday");
        chk(RA_DAY,  8'h01, "R1 day");
        chk(RA_MON,  8'h01, "R1 month");
        chk(RA_YEAR, 8'h00, "R1 year");
        chk(RA_CTL1, 8'h00, "R1 ctl1");
        chk(RA_CTL2, 8'h10, "R1 ctl2");
        chk(4'd7,    8'h00, "R1 unused addr 7");
        chk(4'd10,   8'h00, "R1 unused addr 10");

        // R2 mask and carry
        wr(RA_SEC, 8'hD8);
        chk(RA_SEC, 8'h58, "R2 bit7 masked");
        tick1();
        chk(RA_SEC, 8'h59, "R2 step");
        tick1();
        chk(RA_SEC, 8'h00, "R2 wrap");
        chk(RA_MIN, 8'h01, "R2 carry");
        wr(RA_MIN, 8'hD9);
        chk(RA_MIN, 8'h59, "R2 min bit7 masked");
        wr(RA_SEC, 8'h59);
        tick1();
        chk(RA_MIN,  8'h00, "R2 min wrap");
        chk(RA_HOUR, 8'h01, "R4 12AM to 01AM");
        chk(RA_WDAY, 8'h00, "R4 no date step at 12AM");

        // R12 idle hold
        repeat (20) @(negedge clk);
        chk(RA_SEC,  8'h00, "R12 sec held");
        chk(RA_HOUR, 8'h01, "R12 hour held");

        // R4 12-hour layout
        wr(RA_HOUR, 8'h11);
        wr(RA_MIN, 8'h59);
        wr(RA_SEC, 8'h59);
        tick1();
        chk(RA_HOUR, 8'h32, "R4 11AM to 12PM");
        wr(RA_MIN, 8'h59);
        wr(RA_SEC, 8'h59);
        tick1();
        chk(RA_HOUR, 8'h21, "R4 12PM to 01PM");
        wr(RA_HOUR, 8'h31);
        wr(RA_MIN, 8'h59);
        wr(RA_SEC, 8'h59);
        tick1();
        chk(RA_HOUR, 8'h12, "R4 11PM to 12AM");
        chk(RA_WDAY, 8'h01, "R5 step on midnight");
        chk(RA_DAY,  8'h02, "R4 date advanced");

        // R3 24-hour layout, R6 30-day month
        wr(RA_CTL1, 8'h20);
        chk(RA_CTL1, 8'h20, "R3 mode bit");
        wr(RA_DAY, 8'h30);
        wr(RA_MON, 8'h04);
        set_eod();
        tick1();
        chk(RA_HOUR, 8'h00, "R3 23 to 00");
        chk(RA_DAY,  8'h01, "R6 30-day wrap");
        chk(RA_MON,  8'h05, "R6 month step");
        chk(RA_WDAY, 8'h02, "R5 step");
        wr(RA_HOUR, 8'h09);
        wr(RA_MIN, 8'h59);
        wr(RA_SEC, 8'h59);
        tick1();
        chk(RA_HOUR, 8'h10, "R3 BCD digit carry");

        // R6 year end
        wr(RA_YEAR, 8'h23);
        wr(RA_MON, 8'h12);
        wr(RA_DAY, 8'h31);
        set_eod();
        tick1();
        chk(RA_DAY,  8'h01, "R6 31-day wrap");
        chk(RA_MON,  8'h01, "R6 month 12 to 01");
        chk(RA_YEAR, 8'h24, "R6 year step");

        // R7 February
        feb_case(8'h24, 8'h29, 8'h02);
        set_eod();
        tick1();
        chk(RA_DAY, 8'h01, "R7 after 29th");
        chk(RA_MON, 8'h03, "R7 to March");
        feb_case(8'h23, 8'h01, 8'h03);
        feb_case(8'h00, 8'h29, 8'h02);
        feb_case(8'h10, 8'h01, 8'h03);
        feb_case(8'h12, 8'h29, 8'h02);

        // R8 century
        wr(RA_YEAR, 8'h99);
        wr(RA_MON, 8'h12);
        wr(RA_DAY, 8'h31);
        set_eod();
        tick1();
        chk(RA_MON,  8'h81, "R8 century set");
        chk(RA_YEAR, 8'h00, "R8 99 to 00");
        wr(RA_MON, 8'h85);
        chk(RA_MON, 8'h85, "R8 century written");
        wr(RA_YEAR, 8'h99);
        wr(RA_MON, 8'h92);
        wr(RA_DAY, 8'h31);
        set_eod();
        tick1();
        chk(RA_MON, 8'h01, "R8 century toggles back");

        // R5 weekday wrap
        wr(RA_WDAY, 8'h06);
        set_eod();
        tick1();
        chk(RA_WDAY, 8'h00, "R5 6 to 0");

        // R9 oscillator flag
        wr(RA_CTL2, 8'h10);
        chk(RA_CTL2, 8'h10, "R9 writing 1 keeps");
        wr(RA_CTL2, 8'h00);
        chk(RA_CTL2, 8'h00, "R9 cleared");
        wr(RA_CTL2, 8'h10);
        chk(RA_CTL2, 8'h00, "R9 not set by write");
        @(negedge clk);
        total++;
        if (osc_stopped !== 1'b0) begin
            fails++;
            $display("FAIL R9 osc_stopped port actual=%0b expected=0", osc_stopped);
        end

        // R10 voltage-low flag
        @(negedge clk);
        volt_low_in = 1'b1;
        @(negedge clk);
        volt_low_in = 1'b0;
        chk(RA_CTL2, 8'h40, "R10 latched");
        wr(RA_CTL2, 8'h00);
        chk(RA_CTL2, 8'h00, "R10 cleared");
        @(negedge clk);
        volt_low_in = 1'b1;
        wr(RA_CTL2, 8'h00);
        chk(RA_CTL2, 8'h40, "R10 set wins over clear");
        volt_low_in = 1'b0;

        // R11 write and tick together
        wr(RA_MIN, 8'h10);
        wr(RA_SEC, 8'h59);
        wr_tick(RA_SEC, 8'h30);
        chk(RA_SEC, 8'h30, "R11 written sec kept");
        chk(RA_MIN, 8'h11, "R11 carry from old sec");
        wr(RA_SEC, 8'h05);
        wr_tick(RA_MIN, 8'h20);
        chk(RA_MIN, 8'h20, "R11 written min kept");
        chk(RA_SEC, 8'h06, "R11 sec still advances");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule